// File: doc/BRIEF.md
# Interrupt and Acknowledge Pin Controller

This block drives two status pins of a converter interface from internal events. The acknowledge pin shows new data as a one-clock pulse. The interrupt pin shows that at least one enabled source flag is pending. Each source has a sticky flag. An event pulse sets the flag. The host clears it with a write-one-to-clear mask. A per-source enable mask gates both setting and clearing.

Three control bits shape the behaviour. The acknowledge polarity bit picks a high or a low active level for the acknowledge pin. The interrupt polarity bit picks whether an interrupt is seen as a rising or a falling transition. The interrupt pin rests at its idle level and moves to the opposite level while any enabled flag is pending. A master enable blocks everything. When it is low, the interrupt pin is held idle and every flag is frozen, so no event sets a flag and no clear removes one.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After a synchronous reset, every flag reads 0 and both pins are low.
- R2: The acknowledge pin rests at the level of `ack_pol_i`. One clock after `new_data_i` is sampled high, the pin shows the opposite level for exactly one cycle.
- R3: The interrupt pin is at the level of `irq_pol_i` when idle and at the inverse when active. With polarity 0 an interrupt is therefore a rising edge, and with polarity 1 it is a falling edge.
- R4: While `master_en_i` is 0, no flag changes and the interrupt pin is at its idle level one clock later.
- R5: A flag whose bit in `src_en_i` is 0 is neither set by its event nor cleared by the clear mask.
- R6: With the master enable and the source enable both at 1, an event pulse on `evt_i[i]` makes `flags_o[i]` read 1 after the next clock edge.
- R7: A cycle with `clr_we_i` high clears every enabled flag whose bit in `clr_mask_i` is 1, and leaves the other flags unchanged.
- R8: If an event and a clear of the same enabled flag fall in the same cycle, the flag stays set.
- R9: The interrupt pin becomes active one clock after the master enable is 1 and any flag that is both pending and enabled is seen. It returns to idle one clock after no such flag remains.
- R10: A change of either polarity bit while its pin is idle moves the pin to the new idle level on the next clock, with no active pulse in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ack_pol_i | input | 1 | Acknowledge polarity: 0 = active high, 1 = active low |
| irq_pol_i | input | 1 | Interrupt polarity: 0 = rising, 1 = falling |
| master_en_i | input | 1 | Master interrupt enable |
| src_en_i | input | NUM_SRC | Per-source enable mask |
| evt_i | input | NUM_SRC | Per-source event pulses |
| new_data_i | input | 1 | New-data pulse |
| clr_we_i | input | 1 | Write strobe for the clear mask |
| clr_mask_i | input | NUM_SRC | Write-one-to-clear mask |
| flags_o | output | NUM_SRC | Flag readback |
| irq_pin_o | output | 1 | Interrupt pin |
| ack_pin_o | output | 1 | Acknowledge pin |

## Verification
An event that sets a flag and a host clear of that same flag can arrive in the same cycle. The bench provokes this by driving `evt_i` and a matching `clr_mask_i` bit with `clr_we_i` on one clock. It judges the result by the readback after that edge, which must still show the flag set. The next clear-only cycle must then remove the flag, and the interrupt pin must drop back to idle one clock later.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int unsigned DEF_NUM_SRC = 8;

  // pin level for a given activity and polarity selection
  function automatic logic pin_level(input logic active, input logic pol);
    return active ^ pol;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               master_en_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  output logic [NUM_SRC-1:0] flags_o
);
  logic [NUM_SRC-1:0] flag_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    logic open_w;
    logic clr_w;
    assign open_w = master_en_i & src_en_i[g];
    assign clr_w  = clr_we_i & clr_mask_i[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[g] <= 1'b0;
      end else if (open_w) begin
        // set has priority over a simultaneous clear
        flag_q[g] <= (flag_q[g] & ~clr_w) | evt_i[g];
      end
    end

    assert_set_R6: assert property (@(posedge clk) disable iff (rst)
      (master_en_i && src_en_i[g] && evt_i[g]) |=> flags_o[g]);

    assert_gate_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (master_en_i && !src_en_i[g]) |=> (flags_o[g] == $past(flags_o[g])));

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
      (master_en_i && src_en_i[g] && clr_we_i && clr_mask_i[g] && !evt_i[g]) |=> !flags_o[g]);
  end

  assign flags_o = flag_q;

  assert_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    !master_en_i |=> (flags_o == $past(flags_o)));
endmodule

// File: rtl/irq_pin_gen.sv
module irq_pin_gen #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               master_en_i,
  input  logic               irq_pol_i,
  input  logic [NUM_SRC-1:0] flags_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  output logic               irq_pin_o
);
  import irq_ack_pkg::*;

  logic pending_w;
  logic pin_q;

  assign pending_w = master_en_i & (|(flags_i & src_en_i));

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin_level(pending_w, irq_pol_i);
  end

  assign irq_pin_o = pin_q;

  assert_masked_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !master_en_i |=> (irq_pin_o == $past(irq_pol_i)));

  assert_no_pending_idle_R9: assert property (@(posedge clk) disable iff (rst)
    ((flags_i & src_en_i) == '0) |=> (irq_pin_o == $past(irq_pol_i)));
endmodule

// File: rtl/ack_pin_gen.sv
module ack_pin_gen (
  input  logic clk,
  input  logic rst,
  input  logic ack_pol_i,
  input  logic new_data_i,
  output logic ack_pin_o
);
  import irq_ack_pkg::*;

  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin_level(new_data_i, ack_pol_i);
  end

  assign ack_pin_o = pin_q;

  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    new_data_i |=> (ack_pin_o != $past(ack_pol_i)));

  assert_ack_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !new_data_i |=> (ack_pin_o == $past(ack_pol_i)));
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl #(
  parameter int unsigned NUM_SRC = irq_ack_pkg::DEF_NUM_SRC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ack_pol_i,
  input  logic               irq_pol_i,
  input  logic               master_en_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               new_data_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  output logic [NUM_SRC-1:0] flags_o,
  output logic               irq_pin_o,
  output logic               ack_pin_o
);
  logic [NUM_SRC-1:0] flags_w;

  irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk         (clk),
    .rst         (rst),
    .master_en_i (master_en_i),
    .src_en_i    (src_en_i),
    .evt_i       (evt_i),
    .clr_we_i    (clr_we_i),
    .clr_mask_i  (clr_mask_i),
    .flags_o     (flags_w)
  );

  irq_pin_gen #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk         (clk),
    .rst         (rst),
    .master_en_i (master_en_i),
    .irq_pol_i   (irq_pol_i),
    .flags_i     (flags_w),
    .src_en_i    (src_en_i),
    .irq_pin_o   (irq_pin_o)
  );

  ack_pin_gen u_ack (
    .clk        (clk),
    .rst        (rst),
    .ack_pol_i  (ack_pol_i),
    .new_data_i (new_data_i),
    .ack_pin_o  (ack_pin_o)
  );

  assign flags_o = flags_w;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (flags_o == '0 && !irq_pin_o && !ack_pin_o));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (master_en_i && ((src_en_i & evt_i & clr_mask_i) != '0) && clr_we_i)
      |=> ((flags_o & $past(src_en_i & evt_i & clr_mask_i)) == $past(src_en_i & evt_i & clr_mask_i)));
endmodule

// File: tb/irq_ack_ctrl_tb.sv
module irq_ack_ctrl_tb;
  localparam int N = 8;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst;
  logic ack_pol, irq_pol, men, nd, cw;
  logic [N-1:0] en, ev, cm;
  logic [N-1:0] flags;
  logic irq_pin, ack_pin;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_ack_ctrl #(.NUM_SRC(N)) u_dut (
    .clk(clk), .rst(rst), .ack_pol_i(ack_pol), .irq_pol_i(irq_pol),
    .master_en_i(men), .src_en_i(en), .evt_i(ev), .new_data_i(nd),
    .clr_we_i(cw), .clr_mask_i(cm), .flags_o(flags),
    .irq_pin_o(irq_pin), .ack_pin_o(ack_pin)
  );

  // {ap, ip, me, en, ev, nd, cw, cm, exp_flags, exp_irq, exp_ack}
  localparam logic [38:0] VEC [NV] = '{
    {1'b0,1'b0,1'b1,8'hFF,8'h01,1'b0,1'b0,8'h00, 8'h01,1'b0,1'b0}, // R6 set
    {1'b0,1'b0,1'b1,8'hFF,8'h00,1'b1,1'b0,8'h00, 8'h01,1'b1,1'b1}, // R9 rise, R2 pulse
    {1'b0,1'b0,1'b1,8'hFF,8'h02,1'b0,1'b1,8'h01, 8'h02,1'b1,1'b0}, // R7 clear one, set other
    {1'b0,1'b0,1'b1,8'hFF,8'h02,1'b0,1'b1,8'h02, 8'h02,1'b1,1'b0}, // R8 set wins
    {1'b0,1'b0,1'b1,8'hFF,8'h00,1'b0,1'b1,8'h02, 8'h00,1'b1,1'b0}, // R7 clear
    {1'b0,1'b0,1'b1,8'hFF,8'h00,1'b0,1'b0,8'h00, 8'h00,1'b0,1'b0}, // R9 back to idle
    {1'b1,1'b1,1'b1,8'h0F,8'hF0,1'b0,1'b0,8'h00, 8'h00,1'b1,1'b1}, // R5 masked set, R10 idle levels
    {1'b1,1'b1,1'b1,8'h0F,8'h04,1'b1,1'b0,8'h00, 8'h04,1'b1,1'b0}, // R2 active low ack
    {1'b1,1'b1,1'b1,8'h0F,8'h00,1'b0,1'b0,8'h00, 8'h04,1'b0,1'b1}, // R3 falling interrupt
    {1'b1,1'b1,1'b0,8'h0F,8'h01,1'b0,1'b1,8'h04, 8'h04,1'b1,1'b1}, // R4 frozen, pin idle
    {1'b1,1'b1,1'b1,8'h0B,8'h00,1'b0,1'b1,8'h04, 8'h04,1'b1,1'b1}, // R5 masked clear
    {1'b1,1'b1,1'b1,8'h0F,8'h00,1'b0,1'b1,8'h04, 8'h00,1'b0,1'b1}, // R7 clear enabled
    {1'b1,1'b1,1'b1,8'h0F,8'h00,1'b0,1'b0,8'h00, 8'h00,1'b1,1'b1}  // R9 idle again
  };
  localparam logic [23:0] TAG [NV] = '{
    "R6 ", "R9 ", "R7 ", "R8 ", "R7 ", "R9 ", "R5 ",
    "R2 ", "R3 ", "R4 ", "R5 ", "R7 ", "R9 "
  };

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in();
    ev = '0; nd = 1'b0; cw = 1'b0; cm = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; ack_pol = 1'b0; irq_pol = 1'b0; men = 1'b0; en = '0;
    idle_in();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(flags, 8'h00, "R1 flags");
    check({7'd0, irq_pin}, 8'h00, "R1 irq");
    check({7'd0, ack_pin}, 8'h00, "R1 ack");

    for (int i = 0; i < NV; i++) begin
      {ack_pol, irq_pol, men, en, ev, nd, cw, cm} = VEC[i][38:10];
      tick();
      check(flags, VEC[i][9:2], $sformatf("%s vec %0d flags", TAG[i], i));
      check({7'd0, irq_pin}, {7'd0, VEC[i][1]}, $sformatf("%s vec %0d irq", TAG[i], i));
      check({7'd0, ack_pin}, {7'd0, VEC[i][0]}, $sformatf("%s vec %0d ack", TAG[i], i));
    end

    // R10: idle polarity swap, no active pulse
    idle_in(); men = 1'b1; en = 8'hFF;
    irq_pol = 1'b0; ack_pol = 1'b0;
    tick();
    check({6'd0, irq_pin, ack_pin}, 8'h00, "R10 new idle low");
    tick();
    check({6'd0, irq_pin, ack_pin}, 8'h00, "R10 stays idle");

    // R4: master disable drops an active interrupt pin
    ev = 8'h80; tick(); idle_in();
    tick();
    check({7'd0, irq_pin}, 8'h01, "R9 active rising");
    men = 1'b0; tick();
    check({7'd0, irq_pin}, 8'h00, "R4 pin idle when masked");
    check(flags, 8'h80, "R4 flag frozen");
    cw = 1'b1; cm = 8'hFF; tick(); idle_in();
    check(flags, 8'h80, "R4 clear blocked");
    men = 1'b1; tick();
    check({7'd0, irq_pin}, 8'h01, "R3 re-armed active");

    // R1: reset mid-run
    rst = 1'b1; tick(); rst = 1'b0;
    check(flags, 8'h00, "R1 flags after reset");
    check({6'd0, irq_pin, ack_pin}, 8'h00, "R1 pins after reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule